// File: doc/BRIEF.md
# Video Memory Data Port with Read Buffer

This block is the processor's path into a 14-bit video address space. Software loads a pointer with two byte writes to an address register. It then moves bytes through a data register. Each data access advances the pointer by one. Ordinary memory is reached through a synchronous memory port. A small colour-palette store hangs off a second, separate port that reads combinationally.

Reads of ordinary memory pass through a one-entry buffer. Each such read hands back the byte fetched by the previous read and then refills the buffer from the current pointer. Reads inside the top 256 bytes of the space (high address byte 0x3F) return palette data at once. The buffer is still refilled on these reads, from the ordinary memory that lies 0x1000 below the raw pointer. Reading the status register restarts the two-write address sequence.

Top module: `vmp_port`

## Requirements
- R1: While reset is held and directly after it, the pointer is 0x0000, the buffer holds 0x00, `cpu_rdata` is 0x00, and both write enables are low.
- R2: Writes to the address register (select 1) alternate between two roles. The first supplies the upper six pointer bits from data bits 5:0, and the second supplies the lower eight bits. The new pointer takes effect after the second write.
- R3: A read of the status register (select 0) returns 0x00 and makes the next address-register write the high-byte write.
- R4: A data-register (select 2) read with pointer high byte below 0x3F returns the buffer's old contents. The buffer is loaded one cycle later with the memory byte at that pointer.
- R5: Every data-register read or write advances the pointer by one, modulo 2^14.
- R6: A data write with pointer high byte below 0x3F drives `mem_we` with the pointer and the data, and leaves the buffer unchanged.
- R7: A data write with pointer high byte 0x3F drives `pal_we` with pointer bits 4:0 as palette address. It does not assert `mem_we` and leaves the buffer unchanged.
- R8: A data read with pointer high byte 0x3F returns the palette byte at pointer bits 4:0. It loads the buffer from memory at the raw pointer minus 0x1000, with no palette aliasing applied.
- R9: `cpu_rdata` changes only in the cycle after a read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 2 | Register select: 0 status, 1 address, 2 data, 3 unused |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_rd | input | 1 | Read strobe, ignored when `cpu_wr` is high |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid the cycle after a read strobe |
| mem_addr | output | 14 | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after the address |
| pal_addr | output | 5 | Palette address |
| pal_we | output | 1 | Palette write enable |
| pal_wdata | output | 8 | Palette write data |
| pal_rdata | input | 8 | Palette read data, same cycle |

## Verification
The bench targets the one-access delay of buffered reads. A port without the buffer would return the current byte one read early. It also checks that writes, to memory or to the palette, leave the buffer alone. A design that captured write data into the buffer would hand that data back on the next read. For palette-range reads, it checks that the value comes straight from the palette. It also checks that the buffer picks up the byte hidden 0x1000 lower, reading 0x3F04 and 0x3F14 separately to catch a design that aliases the address first. It also checks status-read latch clearing, address wrap from 0x3FFF to 0x0000, and that `cpu_rdata` holds between reads.

// File: rtl/vmp_pkg.sv
package vmp_pkg;

    localparam int VMP_AW       = 14;
    localparam int VMP_DW       = 8;
    localparam int VMP_PAW      = 5;
    localparam int VMP_HIDE_OFS = 'h1000;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_ADDR   = 2'd1,
        SEL_DATA   = 2'd2,
        SEL_NONE   = 2'd3
    } vmp_sel_e;

    typedef struct packed {
        logic st_rd;
        logic oth_rd;
        logic adr_wr;
        logic dat_wr;
        logic dat_rd;
    } vmp_cmd_t;

    function automatic vmp_cmd_t vmp_decode(logic [1:0] sel, logic wr, logic rd);
        vmp_cmd_t c;
        logic     rd_ok;
        rd_ok    = rd & ~wr;
        c.st_rd  = rd_ok & (sel == SEL_STATUS);
        c.oth_rd = rd_ok & (sel != SEL_DATA);
        c.adr_wr = wr & (sel == SEL_ADDR);
        c.dat_wr = wr & (sel == SEL_DATA);
        c.dat_rd = rd_ok & (sel == SEL_DATA);
        return c;
    endfunction

endpackage

// File: rtl/vmp_addr_ctrl.sv
module vmp_addr_ctrl
    import vmp_pkg::*;
#(
    parameter int AW = VMP_AW,
    parameter int DW = VMP_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  vmp_cmd_t      cmd,
    input  logic [DW-1:0] wdata,
    output logic [AW-1:0] vaddr,
    output logic          second
);
    localparam int HI_W = AW - DW;

    logic [HI_W-1:0] hi_stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            vaddr    <= '0;
            hi_stage <= '0;
            second   <= 1'b0;
        end else if (cmd.st_rd) begin
            second <= 1'b0;
        end else if (cmd.adr_wr) begin
            if (!second) begin
                hi_stage <= wdata[HI_W-1:0];
                second   <= 1'b1;
            end else begin
                vaddr  <= {hi_stage, wdata};
                second <= 1'b0;
            end
        end else if (cmd.dat_wr || cmd.dat_rd) begin
            vaddr <= vaddr + AW'(1);
        end
    end

endmodule

// File: rtl/vmp_route.sv
module vmp_route
    import vmp_pkg::*;
#(
    parameter int AW       = VMP_AW,
    parameter int DW       = VMP_DW,
    parameter int PAW      = VMP_PAW,
    parameter int HIDE_OFS = VMP_HIDE_OFS
) (
    input  vmp_cmd_t       cmd,
    input  logic [AW-1:0]  vaddr,
    input  logic [DW-1:0]  wdata,
    output logic           in_pal,
    output logic [AW-1:0]  mem_addr,
    output logic           mem_we,
    output logic [DW-1:0]  mem_wdata,
    output logic [PAW-1:0] pal_addr,
    output logic           pal_we,
    output logic [DW-1:0]  pal_wdata
);
    localparam int HI_W = AW - 8;

    always_comb begin
        in_pal    = (vaddr[AW-1:8] == {HI_W{1'b1}});
        mem_addr  = in_pal ? (vaddr - AW'(HIDE_OFS)) : vaddr;
        mem_we    = cmd.dat_wr & ~in_pal;
        mem_wdata = wdata;
        pal_addr  = vaddr[PAW-1:0];
        pal_we    = cmd.dat_wr & in_pal;
        pal_wdata = wdata;
    end

endmodule

// File: rtl/vmp_read_buf.sv
module vmp_read_buf
    import vmp_pkg::*;
#(
    parameter int DW = VMP_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  vmp_cmd_t      cmd,
    input  logic          in_pal,
    input  logic [DW-1:0] mem_rdata,
    input  logic [DW-1:0] pal_rdata,
    output logic [DW-1:0] rbuf,
    output logic          pend,
    output logic [DW-1:0] cpu_rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rbuf      <= '0;
            pend      <= 1'b0;
            cpu_rdata <= '0;
        end else begin
            pend <= cmd.dat_rd;
            if (pend) begin
                rbuf <= mem_rdata;
            end
            if (cmd.dat_rd) begin
                cpu_rdata <= in_pal ? pal_rdata : rbuf;
            end else if (cmd.oth_rd) begin
                cpu_rdata <= '0;
            end
        end
    end

endmodule

// File: rtl/vmp_port.sv
module vmp_port
    import vmp_pkg::*;
#(
    parameter int AW       = VMP_AW,
    parameter int DW       = VMP_DW,
    parameter int PAW      = VMP_PAW,
    parameter int HIDE_OFS = VMP_HIDE_OFS
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [1:0]     cpu_sel,
    input  logic           cpu_wr,
    input  logic           cpu_rd,
    input  logic [DW-1:0]  cpu_wdata,
    output logic [DW-1:0]  cpu_rdata,
    output logic [AW-1:0]  mem_addr,
    output logic           mem_we,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    output logic [PAW-1:0] pal_addr,
    output logic           pal_we,
    output logic [DW-1:0]  pal_wdata,
    input  logic [DW-1:0]  pal_rdata
);
    vmp_cmd_t      cmd;
    logic [AW-1:0] vaddr;
    logic          second;
    logic          in_pal;
    logic [DW-1:0] rbuf;
    logic          pend;

    assign cmd = vmp_decode(cpu_sel, cpu_wr, cpu_rd);

    vmp_addr_ctrl #(.AW(AW), .DW(DW)) u_addr (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .wdata  (cpu_wdata),
        .vaddr  (vaddr),
        .second (second)
    );

    vmp_route #(.AW(AW), .DW(DW), .PAW(PAW), .HIDE_OFS(HIDE_OFS)) u_route (
        .cmd       (cmd),
        .vaddr     (vaddr),
        .wdata     (cpu_wdata),
        .in_pal    (in_pal),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .pal_addr  (pal_addr),
        .pal_we    (pal_we),
        .pal_wdata (pal_wdata)
    );

    vmp_read_buf #(.DW(DW)) u_rbuf (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .in_pal    (in_pal),
        .mem_rdata (mem_rdata),
        .pal_rdata (pal_rdata),
        .rbuf      (rbuf),
        .pend      (pend),
        .cpu_rdata (cpu_rdata)
    );

endmodule

// File: rtl/vmp_port_chk.sv
module vmp_port_chk #(
    parameter int AW = 14,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    cpu_sel,
    input logic          cpu_wr,
    input logic          cpu_rd,
    input logic [DW-1:0] cpu_rdata,
    input logic [AW-1:0] mem_addr,
    input logic          mem_we,
    input logic [DW-1:0] mem_rdata,
    input logic          pal_we,
    input logic [AW-1:0] vaddr,
    input logic          second,
    input logic [DW-1:0] rbuf,
    input logic          pend
);
    localparam int HI_W = AW - 8;

    // R5
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        ((cpu_wr || cpu_rd) && cpu_sel == 2'd2) |=> vaddr == AW'($past(vaddr) + AW'(1)));

    // R3
    latch_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && !cpu_wr && cpu_sel == 2'd0) |=> !second);

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cpu_rd || cpu_wr) |=> $stable(cpu_rdata));

    // R6
    buf_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && !pend) |=> $stable(rbuf));

    // R4
    refill_chk: assert property (@(posedge clk) disable iff (rst)
        pend |=> rbuf == $past(mem_rdata));

    // R7
    port_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && pal_we));

    // R6
    mem_range_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr[AW-1:8] != {HI_W{1'b1}}));

endmodule

bind vmp_port vmp_port_chk #(.AW(AW), .DW(DW)) u_vmp_port_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_sel   (cpu_sel),
    .cpu_wr    (cpu_wr),
    .cpu_rd    (cpu_rd),
    .cpu_rdata (cpu_rdata),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_rdata (mem_rdata),
    .pal_we    (pal_we),
    .vaddr     (vaddr),
    .second    (second),
    .rbuf      (rbuf),
    .pend      (pend)
);

// File: tb/vmp_port_bench.sv
`timescale 1ns/1ps
module vmp_port_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cpu_sel = 2'd3;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [7:0]  cpu_wdata = 8'h00;
    logic [7:0]  cpu_rdata;
    logic [13:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic [4:0]  pal_addr;
    logic        pal_we;
    logic [7:0]  pal_wdata;
    logic [7:0]  pal_rdata;

    always #2 clk = ~clk;

    vmp_port u_vmp_port (
        .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .pal_addr(pal_addr), .pal_we(pal_we), .pal_wdata(pal_wdata), .pal_rdata(pal_rdata)
    );

    // environment: synchronous memory and combinational palette
    logic [7:0] env_mem [logic [13:0]];
    logic [7:0] env_pal [32];
    int         memwe_cnt = 0;

    function automatic logic [7:0] env_rd(logic [13:0] a);
        return env_mem.exists(a) ? env_mem[a] : 8'h00;
    endfunction

    always @(posedge clk) begin
        mem_rdata <= env_rd(mem_addr);
        if (mem_we) begin
            env_mem[mem_addr] = mem_wdata;
            memwe_cnt = memwe_cnt + 1;
        end
        if (rst) begin
            for (int i = 0; i < 32; i++) env_pal[i] <= 8'h00;
        end else if (pal_we) begin
            env_pal[pal_addr] <= pal_wdata;
        end
    end
    assign pal_rdata = env_pal[pal_addr];

    // independent model of the requirements
    logic [7:0]  sh_mem [logic [13:0]];
    logic [7:0]  sh_pal [32];
    logic [13:0] m_addr = '0;
    logic [7:0]  m_buf = 8'h00;

    function automatic logic [7:0] sh_rd(logic [13:0] a);
        return sh_mem.exists(a) ? sh_mem[a] : 8'h00;
    endfunction

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic chk(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard
    typedef struct {
        logic [7:0] exp;
        string      tag;
    } sb_item_t;
    sb_item_t sbq[$];
    logic     rd_d = 1'b0;

    always @(posedge clk) rd_d <= !rst && cpu_rd && !cpu_wr && cpu_sel == 2'd2;

    always @(negedge clk) begin
        if (rd_d) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "scoreboard-empty", cpu_rdata, 8'h00);
            end else begin
                sb_item_t it;
                it = sbq.pop_front();
                chk(cpu_rdata === it.exp, it.tag, cpu_rdata, it.exp);
            end
        end
    end

    task automatic strobe(logic [1:0] sel, logic wr, logic rd, logic [7:0] d);
        @(negedge clk);
        cpu_sel = sel; cpu_wr = wr; cpu_rd = rd; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0; cpu_rd = 1'b0; cpu_sel = 2'd3;
        @(negedge clk);
    endtask

    task automatic set_addr(logic [13:0] a);
        strobe(2'd1, 1'b1, 1'b0, {2'b00, a[13:8]});
        strobe(2'd1, 1'b1, 1'b0, a[7:0]);
        m_addr = a;
    endtask

    task automatic wr_data(logic [7:0] d);
        if (m_addr[13:8] == 6'h3F) sh_pal[m_addr[4:0]] = d;
        else sh_mem[m_addr] = d;
        strobe(2'd2, 1'b1, 1'b0, d);
        m_addr = m_addr + 14'd1;
    endtask

    task automatic rd_data(string tag);
        sb_item_t it;
        if (m_addr[13:8] == 6'h3F) begin
            it.exp = sh_pal[m_addr[4:0]];
            m_buf  = sh_rd(m_addr - 14'h1000);
        end else begin
            it.exp = m_buf;
            m_buf  = sh_rd(m_addr);
        end
        it.tag = tag;
        sbq.push_back(it);
        strobe(2'd2, 1'b0, 1'b1, 8'h00);
        m_addr = m_addr + 14'd1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            chk(1'b0, "watchdog", 8'h00, 8'h00);
            finish_run();
        end
    end

    initial begin
        int cnt;
        for (int i = 0; i < 32; i++) sh_pal[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(cpu_rdata === 8'h00, "R1 rdata", cpu_rdata, 8'h00);
        chk({mem_we, pal_we} === 2'b00, "R1 write enables", {6'd0, mem_we, pal_we}, 8'h00);
        chk(mem_addr === 14'h0000, "R1 pointer", mem_addr[7:0], 8'h00);
        rd_data("R1 empty buffer");

        // R4 buffered reads
        set_addr(14'h2F00);
        wr_data(8'h12);
        wr_data(8'h34);
        set_addr(14'h2F00);
        rd_data("R4 stale buffer");
        rd_data("R4 first byte");
        rd_data("R4 second byte R5");

        // R6 write leaves buffer, lands in memory
        set_addr(14'h2F00);
        wr_data(8'h78);
        set_addr(14'h2F00);
        rd_data("R6 prime");
        wr_data(8'h99);
        rd_data("R6 buffer kept");
        chk(env_rd(14'h2F01) === 8'h99, "R6 memory write", env_rd(14'h2F01), 8'h99);

        // R7 palette write
        cnt = memwe_cnt;
        set_addr(14'h3F00);
        wr_data(8'h2A);
        chk(memwe_cnt == cnt, "R7 no memory write", 8'(memwe_cnt - cnt), 8'h00);
        chk(env_pal[0] === 8'h2A, "R7 palette write", env_pal[0], 8'h2A);
        set_addr(14'h2F40);
        rd_data("R7 buffer kept");

        // R8 palette reads and hidden byte
        set_addr(14'h3F00);
        rd_data("R8 palette direct");
        set_addr(14'h2F13);
        rd_data("R8 hidden byte");
        set_addr(14'h2F04);
        wr_data(8'h12);
        set_addr(14'h2F14);
        wr_data(8'h34);
        set_addr(14'h3F04);
        rd_data("R8 palette 04");
        set_addr(14'h2F13);
        rd_data("R8 hidden 2F04");
        set_addr(14'h3F14);
        rd_data("R8 palette 14");
        set_addr(14'h2F13);
        rd_data("R8 hidden 2F14");

        // R3 status read restarts the address sequence
        set_addr(14'h2F20);
        wr_data(8'h5C);
        strobe(2'd1, 1'b1, 1'b0, 8'h2F);
        strobe(2'd0, 1'b0, 1'b1, 8'h00);
        chk(cpu_rdata === 8'h00, "R3 status value", cpu_rdata, 8'h00);
        set_addr(14'h2F20);
        rd_data("R3 prime");
        rd_data("R3 pointer after reset of latch");

        // R2 upper bits of high byte dropped
        strobe(2'd1, 1'b1, 1'b0, 8'hEF);
        strobe(2'd1, 1'b1, 1'b0, 8'h20);
        m_addr = 14'h2F20;
        rd_data("R2 prime");
        rd_data("R2 pointer from two writes");

        // R5 wrap
        set_addr(14'h2FFF);
        wr_data(8'h5A);
        set_addr(14'h0000);
        wr_data(8'hA5);
        set_addr(14'h3FFF);
        rd_data("R5 palette at top");
        rd_data("R5 hidden 2FFF");
        rd_data("R5 wrapped to 0000");

        // R9 hold
        wr_data(8'h11);
        repeat (3) @(negedge clk);
        chk(cpu_rdata === 8'hA5, "R9 hold", cpu_rdata, 8'hA5);
        chk(sbq.size() == 0, "scoreboard drained", 8'(sbq.size()), 8'h00);
        finish_run();
    end

endmodule